// File: doc/BRIEF.md
# SPI Serial-Memory Command Front End

This block is the serial side of a byte-addressed non-volatile memory. It watches a host-driven SPI link (serial clock, active-low select, data in, data out, and an active-low pause input) by oversampling every pin with a faster system clock. It turns the bit stream into commands, and it leaves the memory array and the write-protection policy to the logic around it. Every transaction opens with an 8-bit command byte. Six command codes are understood: write-latch set, write-latch clear, status read, status write, array read and array write.

On an array read the block takes a 16-bit address, most significant bit first. It presents the significant low bits of that address on a synchronous read port and streams the returned bytes out on the data-out line. The address advances through the whole array until the host releases select. On an array write every completed data byte is handed to a page buffer as a strobe carrying address and data. The address wraps inside the current page. When select rises after at least one complete byte, a one-cycle commit pulse tells the page buffer to start programming. The two write-latch commands and the status write only raise strobes toward the protection unit. A status read shifts out the status byte the protection unit supplies, again and again, so a host can poll the ready flag.

Both clock polarities are handled: idle-low (mode 0) and idle-high (mode 3). In both, input bits are taken on rising serial-clock edges and output bits change on falling edges.

Top module: `spiMemCmdSlave`

## Requirements
- R1: While select is high, or before the first byte of a reply has been loaded, `soEn` is 0. A rising select discards any partly received command, so the next transaction decodes its first byte as a command.
- R2: Input bits are taken on rising serial-clock edges, most significant bit first, with the clock idling low (mode 0) or high (mode 3).
- R3: Output bits change on falling serial-clock edges, most significant bit first. The first bit of a reply appears at the first falling edge after the last bit of the command or address.
- R4: Command 0x06 gives exactly one `wrenStb` pulse and command 0x04 gives exactly one `wrdiStb` pulse. Any further bytes in those transactions have no effect.
- R5: Any command byte other than 0x01, 0x02, 0x03, 0x04, 0x05 or 0x06 raises no strobe and never enables `soEn` for the rest of that transaction.
- R6: Command 0x01 presents the next byte on `wrData` with one `wrsrStb` pulse. Later bytes in that transaction are ignored.
- R7: Command 0x02 takes a 16-bit address of which only the low ADDR_BITS bits count. Each complete data byte raises `wrStb` with `wrAddr`/`wrData`. The address then advances in its low log2(PAGE_BYTES) bits only, wrapping to the start of the page.
- R8: `wrCommit` pulses for one cycle when select rises after a write command that received at least one complete data byte, and not otherwise.
- R9: Command 0x03 takes a 16-bit address (low ADDR_BITS bits kept) and sets `rdAddr` to it. It streams bytes from `rdData` (valid one clock after `rdAddr`), advancing `rdAddr` after each byte and wrapping from the last address to 0.
- R10: Command 0x05 shifts out `statusIn` continuously. The value is taken again at the start of every output byte.
- R11: If `busy` is high when the command byte completes, every command except 0x05 is ignored: no strobe, and `soEn` stays 0.
- R12: Taking `holdN` low while the serial clock is low sets `soEn` to 0 and makes serial-clock edges have no effect. Taking it high again while the clock is low resumes the transfer with no bit lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the host |
| csN | input | 1 | Active-low select from the host |
| si | input | 1 | Serial data from the host |
| holdN | input | 1 | Active-low pause request |
| so | output | 1 | Serial data to the host |
| soEn | output | 1 | Output-enable for `so`; 0 means high impedance |
| busy | input | 1 | Internal write cycle in progress |
| statusIn | input | 8 | Status byte returned by the status read |
| rdAddr | output | ADDR_BITS | Array read address |
| rdData | input | 8 | Array read data, one clock after `rdAddr` |
| wrStb | output | 1 | One data byte for the page buffer |
| wrAddr | output | ADDR_BITS | Address of the byte in `wrData` |
| wrData | output | 8 | Received data byte (array write or status write) |
| wrsrStb | output | 1 | Status-write byte valid on `wrData` |
| wrenStb | output | 1 | Write-latch set command received |
| wrdiStb | output | 1 | Write-latch clear command received |
| wrCommit | output | 1 | Start of programming after an array write |

## Verification
The hardest situation to reach is a pause in the middle of an outgoing read byte. The host has to lower `holdN` between two bits while the clock is low, wiggle the serial clock while paused, and then release. The bench stops a read after three bits of a data byte, toggles the clock twice under the pause and checks that `soEn` is low. It then finishes the byte and one more, and compares both with the array model. A second hard spot is the page-wrap and array-wrap of the address. The bench reaches it by starting a write two bytes before a page end, and a read two bytes before the array end, with junk in the ignored upper address bits.

// File: rtl/spiMemCmdPkg.sv
package spiMemCmdPkg;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  typedef enum logic [2:0] {
    S_OPC, S_ADDRH, S_ADDRL, S_WDATA, S_RDATA, S_STAT, S_WRSR, S_SKIP
  } cmdState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capHi;   // latch upper address byte
    logic capLo;   // latch lower address byte, load address counter
    logic wrAdv;   // step address inside page
    logic txRead;  // reply with array data
    logic txStat;  // reply with status byte
  } dpCtl_t;

endpackage

// File: rtl/spiFrontEnd.sv
module spiFrontEnd #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sck,
  input  logic csN,
  input  logic si,
  input  logic holdN,
  output logic sckRise,
  output logic sckFall,
  output logic csFall,
  output logic csRise,
  output logic sel,
  output logic holdActive,
  output logic siBit
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] sckSync, csSync, siSync, holdSync;
  logic sckPrev, csPrev;
  logic sckS, csS, holdS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckSync    <= '0;
      csSync     <= '1;
      siSync     <= '0;
      holdSync   <= '1;
      sckPrev    <= 1'b0;
      csPrev     <= 1'b1;
      holdActive <= 1'b0;
    end else begin
      sckSync  <= {sckSync[TOP-1:0], sck};
      csSync   <= {csSync[TOP-1:0], csN};
      siSync   <= {siSync[TOP-1:0], si};
      holdSync <= {holdSync[TOP-1:0], holdN};
      sckPrev  <= sckS;
      csPrev   <= csS;
      // pause state may only change while the serial clock is low
      if (!sckS) holdActive <= ~holdS;
    end
  end

  assign sckS    = sckSync[TOP];
  assign csS     = csSync[TOP];
  assign holdS   = holdSync[TOP];
  assign siBit   = siSync[TOP];
  assign sel     = ~csS;
  assign sckRise = sckS & ~sckPrev & sel & ~holdActive;
  assign sckFall = ~sckS & sckPrev & sel & ~holdActive;
  assign csFall  = csPrev & ~csS;
  assign csRise  = ~csPrev & csS;

endmodule

// File: rtl/spiDatapath.sv
module spiDatapath
  import spiMemCmdPkg::*;
#(
  parameter int ADDR_BITS  = 11,
  parameter int PAGE_BYTES = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sckRise,
  input  logic                 sckFall,
  input  logic                 csFall,
  input  logic                 csRise,
  input  logic                 sel,
  input  logic                 holdActive,
  input  logic                 siBit,
  input  dpCtl_t               ctl,
  input  logic [7:0]           rdData,
  input  logic [7:0]           statusIn,
  output logic                 byteDone,
  output logic [7:0]           rxByte,
  output logic [ADDR_BITS-1:0] curAddr,
  output logic                 so,
  output logic                 soEn
);
  localparam int PAGE_BITS = $clog2(PAGE_BYTES);

  logic [2:0] bitCnt;
  logic [7:0] rxShift, txShift, addrHi, txByte;
  logic       txActive;
  logic       byteStart;

  assign byteStart = sckFall && (bitCnt == 3'd0) && (ctl.txRead || ctl.txStat);
  assign txByte    = ctl.txRead ? rdData : statusIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      rxShift  <= '0;
      txShift  <= '0;
      addrHi   <= '0;
      curAddr  <= '0;
      byteDone <= 1'b0;
      txActive <= 1'b0;
      so       <= 1'b0;
    end else if (csFall || csRise) begin
      bitCnt   <= '0;
      byteDone <= 1'b0;
      txActive <= 1'b0;
    end else begin
      byteDone <= sckRise && (bitCnt == 3'd7);
      if (sckRise) begin
        rxShift <= {rxShift[6:0], siBit};
        bitCnt  <= bitCnt + 3'd1;
      end
      if (ctl.capHi) addrHi <= rxShift;
      if (ctl.capLo)
        curAddr <= ADDR_BITS'({addrHi, rxShift});
      else if (ctl.wrAdv)
        curAddr <= {curAddr[ADDR_BITS-1:PAGE_BITS],
                    curAddr[PAGE_BITS-1:0] + PAGE_BITS'(1)};
      else if (byteStart && ctl.txRead)
        curAddr <= curAddr + ADDR_BITS'(1);
      if (byteStart) begin
        so       <= txByte[7];
        txShift  <= {txByte[6:0], 1'b0};
        txActive <= 1'b1;
      end else if (sckFall && txActive) begin
        so      <= txShift[7];
        txShift <= {txShift[6:0], 1'b0};
      end
    end
  end

  assign rxByte = rxShift;
  assign soEn   = txActive & sel & ~holdActive;

endmodule

// File: rtl/spiCtrl.sv
module spiCtrl
  import spiMemCmdPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       csFall,
  input  logic       csRise,
  input  logic       byteDone,
  input  logic [7:0] rxByte,
  input  logic       busy,
  output dpCtl_t     ctl,
  output logic       wrStb,
  output logic       wrsrStb,
  output logic       wrenStb,
  output logic       wrdiStb,
  output logic       wrCommit
);
  cmdState_e state;
  logic      isRead, gotData, opcOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_OPC;
      isRead  <= 1'b0;
      gotData <= 1'b0;
    end else if (csFall || csRise) begin
      state   <= S_OPC;
      gotData <= 1'b0;
    end else if (byteDone) begin
      case (state)
        S_OPC: begin
          if (busy && rxByte != OP_RDSR) state <= S_SKIP;
          else begin
            case (rxByte)
              OP_RDSR:  state <= S_STAT;
              OP_WRSR:  state <= S_WRSR;
              OP_READ:  begin state <= S_ADDRH; isRead <= 1'b1; end
              OP_WRITE: begin state <= S_ADDRH; isRead <= 1'b0; end
              default:  state <= S_SKIP;
            endcase
          end
        end
        S_ADDRH: state <= S_ADDRL;
        S_ADDRL: state <= isRead ? S_RDATA : S_WDATA;
        S_WDATA: gotData <= 1'b1;
        S_WRSR:  state <= S_SKIP;
        default: state <= state;
      endcase
    end
  end

  assign opcOk      = byteDone && (state == S_OPC) && !busy;
  assign wrenStb    = opcOk && (rxByte == OP_WREN);
  assign wrdiStb    = opcOk && (rxByte == OP_WRDI);
  assign wrsrStb    = byteDone && (state == S_WRSR);
  assign wrStb      = byteDone && (state == S_WDATA);
  assign wrCommit   = csRise && gotData;

  assign ctl.capHi  = byteDone && (state == S_ADDRH);
  assign ctl.capLo  = byteDone && (state == S_ADDRL);
  assign ctl.wrAdv  = wrStb;
  assign ctl.txRead = (state == S_RDATA);
  assign ctl.txStat = (state == S_STAT);

endmodule

// File: rtl/spiMemCmdSlave.sv
module spiMemCmdSlave
  import spiMemCmdPkg::*;
#(
  parameter int ADDR_BITS   = 11,
  parameter int PAGE_BYTES  = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sck,
  input  logic                 csN,
  input  logic                 si,
  input  logic                 holdN,
  output logic                 so,
  output logic                 soEn,
  input  logic                 busy,
  input  logic [7:0]           statusIn,
  output logic [ADDR_BITS-1:0] rdAddr,
  input  logic [7:0]           rdData,
  output logic                 wrStb,
  output logic [ADDR_BITS-1:0] wrAddr,
  output logic [7:0]           wrData,
  output logic                 wrsrStb,
  output logic                 wrenStb,
  output logic                 wrdiStb,
  output logic                 wrCommit
);
  logic sckRise, sckFall, csFall, csRise, sel, holdActive, siBit;
  logic byteDone;
  logic [7:0] rxByte;
  logic [ADDR_BITS-1:0] curAddr;
  dpCtl_t ctl;

  spiFrontEnd #(.SYNC_STAGES(SYNC_STAGES)) u_fe (
    .clk(clk), .rstN(rstN), .sck(sck), .csN(csN), .si(si), .holdN(holdN),
    .sckRise(sckRise), .sckFall(sckFall), .csFall(csFall), .csRise(csRise),
    .sel(sel), .holdActive(holdActive), .siBit(siBit)
  );

  spiDatapath #(.ADDR_BITS(ADDR_BITS), .PAGE_BYTES(PAGE_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .sckRise(sckRise), .sckFall(sckFall),
    .csFall(csFall), .csRise(csRise), .sel(sel), .holdActive(holdActive),
    .siBit(siBit), .ctl(ctl), .rdData(rdData), .statusIn(statusIn),
    .byteDone(byteDone), .rxByte(rxByte), .curAddr(curAddr),
    .so(so), .soEn(soEn)
  );

  spiCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .csFall(csFall), .csRise(csRise),
    .byteDone(byteDone), .rxByte(rxByte), .busy(busy), .ctl(ctl),
    .wrStb(wrStb), .wrsrStb(wrsrStb), .wrenStb(wrenStb),
    .wrdiStb(wrdiStb), .wrCommit(wrCommit)
  );

  assign rdAddr = curAddr;
  assign wrAddr = curAddr;
  assign wrData = rxByte;

endmodule

// File: rtl/spiMemCmdSlaveChk.sv
module spiMemCmdSlaveChk #(
  parameter int ADDR_BITS = 11
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 csN,
  input logic                 soEn,
  input logic                 wrStb,
  input logic                 wrsrStb,
  input logic                 wrenStb,
  input logic                 wrdiStb,
  input logic                 wrCommit,
  input logic                 holdActive,
  input logic                 byteDone,
  input logic [ADDR_BITS-1:0] rdAddr
);
  // R1: select held high for several cycles keeps the output released
  a_r1_so_off_idle: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2) && $past(csN, 3)) |-> !soEn);

  // R4: command strobes never overlap
  a_r4_strobe_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({wrStb, wrsrStb, wrenStb, wrdiStb, wrCommit}));

  // R8: commit is a single-cycle pulse
  a_r8_commit_pulse: assert property (@(posedge clk) disable iff (!rstN)
    wrCommit |=> !wrCommit);

  // R2: completed bytes are separated in time
  a_r2_byte_spacing: assert property (@(posedge clk) disable iff (!rstN)
    byteDone |=> !byteDone);

  // R12: a held pause freezes byte framing and the address counter
  a_r12_hold_freeze: assert property (@(posedge clk) disable iff (!rstN)
    ($past(holdActive) && $past(holdActive, 2)) |-> (!byteDone && $stable(rdAddr)));

endmodule

bind spiMemCmdSlave spiMemCmdSlaveChk #(.ADDR_BITS(ADDR_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .soEn(soEn), .wrStb(wrStb),
  .wrsrStb(wrsrStb), .wrenStb(wrenStb), .wrdiStb(wrdiStb),
  .wrCommit(wrCommit), .holdActive(holdActive), .byteDone(byteDone),
  .rdAddr(rdAddr)
);

// File: tb/spiMemCmdSlave_tb.sv
module spiMemCmdSlave_tb;
  localparam int AB = 11;
  localparam int H  = 8;   // system clocks per serial half period

  logic clk = 1'b0;
  logic rstN, sck, csN, si, holdN, busy;
  logic so, soEn;
  logic [7:0] statusIn, rdData, wrData;
  logic [AB-1:0] rdAddr, wrAddr;
  logic wrStb, wrsrStb, wrenStb, wrdiStb, wrCommit;

  int errors = 0;
  int checks = 0;
  int expQ[$];
  bit mode3 = 1'b0;
  bit seenEn = 1'b0;
  int csHighCnt = 0;
  int code;

  always #2.5 clk = ~clk;

  spiMemCmdSlave u_dut (
    .clk(clk), .rstN(rstN), .sck(sck), .csN(csN), .si(si), .holdN(holdN),
    .so(so), .soEn(soEn), .busy(busy), .statusIn(statusIn),
    .rdAddr(rdAddr), .rdData(rdData), .wrStb(wrStb), .wrAddr(wrAddr),
    .wrData(wrData), .wrsrStb(wrsrStb), .wrenStb(wrenStb),
    .wrdiStb(wrdiStb), .wrCommit(wrCommit)
  );

  function automatic logic [7:0] memf(input int a);
    return 8'((a * 37 + 11) ^ (a >> 3));
  endfunction

  // array model: one clock read latency
  always @(posedge clk) rdData <= memf(int'(rdAddr));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string tagOf(input int c);
    case (c >> 20)
      1, 2:    return "R4";
      3:       return "R6";
      4:       return "R7";
      default: return "R8";
    endcase
  endfunction

  // per-clock monitor: strobes against the expected event queue, idle output
  always @(negedge clk) begin
    if (rstN) begin
      code = -1;
      if (wrenStb)  code = 1 << 20;
      if (wrdiStb)  code = 2 << 20;
      if (wrsrStb)  code = (3 << 20) | int'(wrData);
      if (wrStb)    code = (4 << 20) | (int'(wrAddr) << 8) | int'(wrData);
      if (wrCommit) code = 5 << 20;
      if (code >= 0) begin
        if (expQ.size() == 0) check({tagOf(code), " unexpected strobe"}, code, 0);
        else check({tagOf(code), " strobe"}, code, expQ.pop_front());
      end
      if (soEn) seenEn = 1'b1;
      csHighCnt = csN ? csHighCnt + 1 : 0;
      if (csHighCnt >= 4) begin
        checks++;
        if (soEn) begin
          errors++;
          $display("FAIL R1 soEn with select high actual=1 expected=0");
        end
      end
    end
  end

  task automatic waitH();
    repeat (H) @(negedge clk);
  endtask

  task automatic bitX(input logic b, output logic r);
    if (mode3) begin
      sck = 1'b0; si = b; waitH(); sck = 1'b1; r = so; waitH();
    end else begin
      si = b; waitH(); sck = 1'b1; r = so; waitH(); sck = 1'b0;
    end
  endtask

  task automatic byteX(input logic [7:0] t, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) bitX(t[i], r[i]);
  endtask

  task automatic startT();
    sck = mode3; waitH(); csN = 1'b0; waitH();
  endtask

  task automatic endT(input string tag);
    waitH(); csN = 1'b1; repeat (3 * H) @(negedge clk);
    check({tag, " pending events"}, expQ.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL all watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] r;
    logic b;
    rstN = 1'b0; sck = 1'b0; csN = 1'b1; si = 1'b0; holdN = 1'b1;
    busy = 1'b0; statusIn = 8'h00;
    repeat (10) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset soEn", int'(soEn), 0);
    check("R1 reset strobes", int'({wrStb, wrsrStb, wrenStb, wrdiStb, wrCommit}), 0);

    // R4 / R2 mode 0: latch set
    mode3 = 1'b0; expQ.push_back(1 << 20);
    startT(); byteX(8'h06, r); endT("R4");

    // R4 / R2 mode 3: latch clear, trailing byte ignored
    mode3 = 1'b1; expQ.push_back(2 << 20);
    startT(); byteX(8'h04, r); byteX(8'h06, r); endT("R4");

    // R1: aborted write address, next transaction decodes fresh command
    mode3 = 1'b0;
    startT(); byteX(8'h02, r); byteX(8'hF0, r); endT("R1");
    expQ.push_back(1 << 20);
    startT(); byteX(8'h06, r); endT("R1");

    // R5: unknown command
    seenEn = 1'b0;
    startT(); byteX(8'hAB, r); byteX(8'h06, r); byteX(8'h02, r); endT("R5");
    check("R5 no output", int'(seenEn), 0);

    // R6: status write
    mode3 = 1'b1; expQ.push_back((3 << 20) | 8'h5A);
    startT(); byteX(8'h01, r); byteX(8'h5A, r); byteX(8'h77, r); endT("R6");

    // R7 / R8: page wrap, upper address bits ignored
    mode3 = 1'b0;
    expQ.push_back((4 << 20) | (12'h03E << 8) | 8'h11);
    expQ.push_back((4 << 20) | (12'h03F << 8) | 8'h22);
    expQ.push_back((4 << 20) | (12'h020 << 8) | 8'h33);
    expQ.push_back((4 << 20) | (12'h021 << 8) | 8'h44);
    expQ.push_back(5 << 20);
    startT(); byteX(8'h02, r); byteX(8'hF8, r); byteX(8'h3E, r);
    byteX(8'h11, r); byteX(8'h22, r); byteX(8'h33, r); byteX(8'h44, r);
    endT("R7");

    // R8: write with no data byte gives no commit
    startT(); byteX(8'h02, r); byteX(8'h00, r); byteX(8'h10, r); endT("R8");

    // R9 / R3 / R2 mode 3: array wrap
    mode3 = 1'b1;
    startT(); byteX(8'h03, r); byteX(8'h07, r); byteX(8'hFE, r);
    byteX(8'h00, r); check("R9 byte at 7FE", r, memf(11'h7FE));
    byteX(8'h00, r); check("R9 byte at 7FF", r, memf(11'h7FF));
    byteX(8'h00, r); check("R9 wrap to 000", r, memf(0));
    byteX(8'h00, r); check("R9 byte at 001", r, memf(1));
    endT("R9");

    // R3 / R2 mode 0: read with junk upper bits
    mode3 = 1'b0;
    startT(); byteX(8'h03, r); byteX(8'hA1, r); byteX(8'h23, r);
    byteX(8'h00, r); check("R3 byte at 123", r, memf(11'h123));
    byteX(8'h00, r); check("R3 byte at 124", r, memf(11'h124));
    endT("R3");

    // R10: repeated status, refreshed per byte (mode 3 boundary at next fall)
    mode3 = 1'b1; statusIn = 8'h8C;
    startT(); byteX(8'h05, r);
    byteX(8'h00, r); check("R10 first status", r, 8'h8C);
    statusIn = 8'h0D;
    byteX(8'h00, r); check("R10 refreshed status", r, 8'h0D);
    endT("R10");

    // R11: busy
    mode3 = 1'b0; busy = 1'b1; statusIn = 8'h01;
    startT(); byteX(8'h06, r); endT("R11");
    startT(); byteX(8'h05, r); byteX(8'h00, r); endT("R11");
    check("R11 status read while busy", r, 8'h01);
    seenEn = 1'b0;
    startT(); byteX(8'h03, r); byteX(8'h00, r); byteX(8'h10, r); byteX(8'h00, r); endT("R11");
    check("R11 read ignored while busy", int'(seenEn), 0);
    busy = 1'b0;

    // R12: pause inside a read byte
    startT(); byteX(8'h03, r); byteX(8'h00, r); byteX(8'h55, r);
    for (int i = 7; i >= 5; i--) begin bitX(1'b0, b); r[i] = b; end
    holdN = 1'b0; waitH();
    check("R12 soEn in pause", int'(soEn), 0);
    sck = 1'b1; waitH(); sck = 1'b0; waitH(); sck = 1'b1; waitH(); sck = 1'b0; waitH();
    check("R12 soEn after clocks in pause", int'(soEn), 0);
    holdN = 1'b1; waitH();
    for (int i = 4; i >= 0; i--) begin bitX(1'b0, b); r[i] = b; end
    check("R12 byte across pause", r, memf(11'h055));
    byteX(8'h00, r); check("R12 next byte", r, memf(11'h056));
    endT("R12");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule